// File: doc/BRIEF.md
# Operand Forwarding Unit for a Five-Stage Integer Pipeline

This block is the execute-side core of a five-stage integer pipeline (fetch, decode, execute, memory, writeback) that runs register arithmetic, immediate arithmetic and shift instructions. It takes one already-decoded instruction per cycle at the decode stage. It reads the register file and carries the instruction through execute, a memory stage that passes results through untouched, and writeback. Data hazards between back-to-back instructions are removed only by bypassing, so an instruction is accepted on every clock and no stall cycle is ever inserted.

In execute, the source register numbers of the current instruction are compared with the destinations held in the execute/memory and memory/writeback pipeline registers. Each operand gets its own 2-bit select that names where its value comes from. When an instruction in decode reads a register that writeback commits on the same edge, the register file passes the new value straight through. Register 0 and instructions that write no register are never used as a bypass source.

Top module: `fwd_pipe`

## Requirements
- R1: After reset, `wb_valid` is 0, both selects are 2'b00 and every register reads as zero.
- R2: An instruction presented on the decode inputs at a rising edge appears on the writeback port exactly three rising edges later. A new instruction is accepted on every edge, with no stall.
- R3: Operation codes on `id_op`: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 NOR, 6 signed set-less-than, 7 unsigned set-less-than, 8 shift left logical, 9 shift right logical, 10 shift right arithmetic, 11 load-upper (operand B shifted left by 16). Codes 12 to 15 give zero. Operand A is the rs value. Operand B is `id_imm` when `id_imm_sel` is 1 and the rt value otherwise. Shifts move the rt value by `id_imm[4:0]` when `id_imm_sel` is 1 and by rs[4:0] otherwise.
- R4: When the instruction in execute reads a register written by the instruction one slot ahead of it, that operand's select is 2'b10 and it receives that result.
- R5: When the match is only with the instruction two slots ahead, that operand's select is 2'b01 and it receives that result.
- R6: A register written by the instruction three slots ahead is read correctly in decode, through write-before-read in the register file.
- R7: When both older stages write the register being read, the newer one (select 2'b10) wins.
- R8: A destination of register 0 is never written, never forwarded and never raises `wb_valid`. Register 0 always reads zero.
- R9: An instruction with `id_wen` at 0 writes no register, raises no `wb_valid` and is never forwarded.
- R10: The two operand selects are decided independently. A select is 2'b00 when no older writer matches its source, and 2'b11 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_wen | input | 1 | Decoded instruction writes a register |
| id_op | input | 4 | Operation code (R3) |
| id_rs | input | 5 | First source register |
| id_rt | input | 5 | Second source register |
| id_rd | input | 5 | Destination register |
| id_imm_sel | input | 1 | Use immediate for operand B and shift amount |
| id_imm | input | 32 | Extended immediate |
| fwd_sel_a | output | 2 | rs operand select of the instruction in execute |
| fwd_sel_b | output | 2 | rt operand select of the instruction in execute |
| wb_valid | output | 1 | Writeback commits a register this cycle |
| wb_reg | output | 5 | Register being written back |
| wb_data | output | 32 | Value being written back |

## Verification
Two bypass paths can fire in the same cycle: one operand can be served from execute/memory while the other comes from memory/writeback. A single source can also match both stages at once. The bench provokes both with random streams over only eight registers and with directed pairs of writes to the same register followed by a read. A sequential reference model computes every result and the expected select for each operand from its own issue history. Every writeback is compared with the model at a fixed latency of three edges, so an added stall or a wrong bypass source shows up as a data or timing mismatch.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NOR  = 4'd5,
        OP_SLT  = 4'd6,
        OP_SLTU = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9,
        OP_SRA  = 4'd10,
        OP_LUI  = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/fwd_regfile.sv
module fwd_regfile #(
    parameter int DATA_W = 32,
    parameter int REG_N  = 32,
    parameter int NRD    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(REG_N)-1:0]   wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [$clog2(REG_N)-1:0]   rd_addr [NRD],
    output logic [DATA_W-1:0]          rd_data [NRD]
);
    localparam int AW = $clog2(REG_N);

    logic [DATA_W-1:0] mem_q [REG_N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_N; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en && wr_addr != '0) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Read ports: register 0 is constant zero; a write landing on the same
    // edge is passed through so decode never sees a stale value.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_addr[p] == AW'(0)) begin
                rd_data[p] = '0;
            end else if (wr_en && wr_addr == rd_addr[p]) begin
                rd_data[p] = wr_data;
            end else begin
                rd_data[p] = mem_q[rd_addr[p]];
            end
        end
    end

    // R8: register 0 keeps reading zero whatever was written
    a_r8_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mem_q[0] == '0);

endmodule

// File: rtl/fwd_select.sv
module fwd_select #(
    parameter int AW = 5
) (
    input  logic          [AW-1:0] ex_rs,
    input  logic          [AW-1:0] ex_rt,
    input  logic                   mem_we,
    input  logic          [AW-1:0] mem_rd,
    input  logic                   wb_we,
    input  logic          [AW-1:0] wb_rd,
    output fwd_pkg::fwd_sel_e      sel_a,
    output fwd_pkg::fwd_sel_e      sel_b
);
    import fwd_pkg::*;

    logic [AW-1:0] src [2];
    fwd_sel_e      sel [2];

    assign src[0] = ex_rs;
    assign src[1] = ex_rt;

    // The newer producer (execute/memory) is tested first, so it wins.
    for (genvar g = 0; g < 2; g++) begin : g_op
        logic hit_mem;
        logic hit_wb;
        assign hit_mem = mem_we && (src[g] != '0) && (mem_rd == src[g]);
        assign hit_wb  = wb_we  && (src[g] != '0) && (wb_rd  == src[g]);
        assign sel[g]  = hit_mem ? SEL_MEM : (hit_wb ? SEL_WB : SEL_RF);
    end

    assign sel_a = sel[0];
    assign sel_b = sel[1];

endmodule

// File: rtl/fwd_alu.sv
module fwd_alu #(
    parameter int DATA_W = 32
) (
    input  fwd_pkg::alu_op_e              op,
    input  logic [DATA_W-1:0]             opa,
    input  logic [DATA_W-1:0]             opb,
    input  logic [DATA_W-1:0]             shv,
    input  logic [$clog2(DATA_W)-1:0]     sha,
    output logic [DATA_W-1:0]             res
);
    import fwd_pkg::*;

    localparam int HALF = DATA_W / 2;

    always_comb begin
        case (op)
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_XOR:  res = opa ^ opb;
            OP_NOR:  res = ~(opa | opb);
            OP_SLT:  res = DATA_W'($signed(opa) < $signed(opb));
            OP_SLTU: res = DATA_W'(opa < opb);
            OP_SLL:  res = shv << sha;
            OP_SRL:  res = shv >> sha;
            OP_SRA:  res = DATA_W'($signed(shv) >>> sha);
            OP_LUI:  res = opb << HALF;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/fwd_pipe.sv
module fwd_pipe #(
    parameter int DATA_W = 32,
    parameter int REG_N  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        id_wen,
    input  logic [3:0]                  id_op,
    input  logic [$clog2(REG_N)-1:0]    id_rs,
    input  logic [$clog2(REG_N)-1:0]    id_rt,
    input  logic [$clog2(REG_N)-1:0]    id_rd,
    input  logic                        id_imm_sel,
    input  logic [DATA_W-1:0]           id_imm,
    output logic [1:0]                  fwd_sel_a,
    output logic [1:0]                  fwd_sel_b,
    output logic                        wb_valid,
    output logic [$clog2(REG_N)-1:0]    wb_reg,
    output logic [DATA_W-1:0]           wb_data
);
    import fwd_pkg::*;

    localparam int AW = $clog2(REG_N);
    localparam int SW = $clog2(DATA_W);

    typedef struct packed {
        logic              we;
        logic [AW-1:0]     rd;
        logic [AW-1:0]     rs;
        logic [AW-1:0]     rt;
        alu_op_e           op;
        logic              imm_sel;
        logic [DATA_W-1:0] imm;
        logic [DATA_W-1:0] rs_val;
        logic [DATA_W-1:0] rt_val;
    } idex_t;

    typedef struct packed {
        logic              we;
        logic [AW-1:0]     rd;
        logic [DATA_W-1:0] val;
    } res_t;

    typedef struct packed {
        idex_t idex;
        res_t  exmem;
        res_t  memwb;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    // ---------------- decode: register read with write-through ----------
    logic [AW-1:0]     rf_addr [2];
    logic [DATA_W-1:0] rf_data [2];

    assign rf_addr[0] = id_rs;
    assign rf_addr[1] = id_rt;

    fwd_regfile #(.DATA_W(DATA_W), .REG_N(REG_N), .NRD(2)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pipe_q.memwb.we),
        .wr_addr (pipe_q.memwb.rd),
        .wr_data (pipe_q.memwb.val),
        .rd_addr (rf_addr),
        .rd_data (rf_data)
    );

    // ---------------- execute: operand selects --------------------------
    fwd_sel_e sel_a, sel_b;

    fwd_select #(.AW(AW)) u_sel (
        .ex_rs  (pipe_q.idex.rs),
        .ex_rt  (pipe_q.idex.rt),
        .mem_we (pipe_q.exmem.we),
        .mem_rd (pipe_q.exmem.rd),
        .wb_we  (pipe_q.memwb.we),
        .wb_rd  (pipe_q.memwb.rd),
        .sel_a  (sel_a),
        .sel_b  (sel_b)
    );

    logic [DATA_W-1:0] rs_fx, rt_fx, opb, alu_y;
    logic [SW-1:0]     sha;

    always_comb begin
        case (sel_a)
            SEL_MEM: rs_fx = pipe_q.exmem.val;
            SEL_WB:  rs_fx = pipe_q.memwb.val;
            default: rs_fx = pipe_q.idex.rs_val;
        endcase
        case (sel_b)
            SEL_MEM: rt_fx = pipe_q.exmem.val;
            SEL_WB:  rt_fx = pipe_q.memwb.val;
            default: rt_fx = pipe_q.idex.rt_val;
        endcase
        opb = pipe_q.idex.imm_sel ? pipe_q.idex.imm : rt_fx;
        sha = pipe_q.idex.imm_sel ? pipe_q.idex.imm[SW-1:0] : rs_fx[SW-1:0];
    end

    fwd_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (pipe_q.idex.op),
        .opa (rs_fx),
        .opb (opb),
        .shv (rt_fx),
        .sha (sha),
        .res (alu_y)
    );

    // ---------------- next-state ----------------------------------------
    always_comb begin
        pipe_d = pipe_q;

        pipe_d.idex.we      = id_wen && (id_rd != '0);
        pipe_d.idex.rd      = id_rd;
        pipe_d.idex.rs      = id_rs;
        pipe_d.idex.rt      = id_rt;
        pipe_d.idex.op      = alu_op_e'(id_op);
        pipe_d.idex.imm_sel = id_imm_sel;
        pipe_d.idex.imm     = id_imm;
        pipe_d.idex.rs_val  = rf_data[0];
        pipe_d.idex.rt_val  = rf_data[1];

        pipe_d.exmem.we     = pipe_q.idex.we;
        pipe_d.exmem.rd     = pipe_q.idex.rd;
        pipe_d.exmem.val    = alu_y;

        // memory stage is a plain passthrough
        pipe_d.memwb        = pipe_q.exmem;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign fwd_sel_a = sel_a;
    assign fwd_sel_b = sel_b;
    assign wb_valid  = pipe_q.memwb.we;
    assign wb_reg    = pipe_q.memwb.rd;
    assign wb_data   = pipe_q.memwb.val;

    // ---------------- assertions ----------------------------------------
    // R2: a commit is exactly the writer presented three edges earlier
    a_r2_wb_latency: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ($past(id_wen, 3) && $past(id_rd, 3) == wb_reg));

    // R8: register 0 never commits
    a_r8_no_zero_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_reg != '0));

    // R10: the unused select code never appears
    a_r10_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a != 2'b11) && (fwd_sel_b != 2'b11));

    // R4: select 10 on rs only when the writer one slot ahead targets it
    a_r4_mem_source: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a == 2'b10) |->
            ($past(id_wen, 2) && $past(id_rd, 2) == $past(id_rs, 1)
             && $past(id_rs, 1) != '0));

    // R5, R7: select 01 on rs only from the writer two slots ahead, and
    // only when the one-slot-ahead instruction does not also write it
    a_r5_wb_source: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a == 2'b01) |->
            ($past(id_wen, 3) && $past(id_rd, 3) == $past(id_rs, 1)
             && $past(id_rs, 1) != '0
             && !($past(id_wen, 2) && $past(id_rd, 2) == $past(id_rs, 1))));

    // R9: a non-writer in execute is never a forwarding source next cycle
    a_r9_quiet_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(id_wen, 2) |-> (fwd_sel_a != 2'b10 && fwd_sel_b != 2'b10));

endmodule

// File: tb/fwd_pipe_test.sv
module fwd_pipe_test;

    localparam int CLK_PERIOD = 10;
    localparam int HMAX       = 4096;
    localparam int NRAND      = 1500;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        id_wen;
    logic [3:0]  id_op;
    logic [4:0]  id_rs, id_rt, id_rd;
    logic        id_imm_sel;
    logic [31:0] id_imm;
    logic [1:0]  fwd_sel_a, fwd_sel_b;
    logic        wb_valid;
    logic [4:0]  wb_reg;
    logic [31:0] wb_data;

    fwd_pipe uut (
        .clk(clk), .rst_n(rst_n), .id_wen(id_wen), .id_op(id_op),
        .id_rs(id_rs), .id_rt(id_rt), .id_rd(id_rd),
        .id_imm_sel(id_imm_sel), .id_imm(id_imm),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // issue history and sequential reference state
    logic        h_wen [HMAX];
    logic [4:0]  h_rd  [HMAX];
    logic [4:0]  h_rs  [HMAX];
    logic [4:0]  h_rt  [HMAX];
    logic [31:0] h_res [HMAX];
    logic        h_d3  [HMAX];
    logic [31:0] mreg  [32];
    int          cnt = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (issue %0d)", tag, act, exp, cnt);
        end
    endtask

    function automatic logic [31:0] ref_alu(input logic [3:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [31:0] sv,
                                            input logic [4:0] sa);
        case (op)
            4'd0:    return a + b;
            4'd1:    return a - b;
            4'd2:    return a & b;
            4'd3:    return a | b;
            4'd4:    return a ^ b;
            4'd5:    return ~(a | b);
            4'd6:    return {31'd0, $signed(a) < $signed(b)};
            4'd7:    return {31'd0, a < b};
            4'd8:    return sv << sa;
            4'd9:    return sv >> sa;
            4'd10:   return 32'($signed(sv) >>> sa);
            4'd11:   return b << 16;
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit writes(input int k, input logic [4:0] r);
        if (k < 0) return 1'b0;
        return h_wen[k] && h_rd[k] != 5'd0 && h_rd[k] == r;
    endfunction

    task automatic chk_sel(input int k, input logic [4:0] src, input logic [1:0] act);
        logic [1:0] exp;
        string tag;
        if (src != 5'd0 && writes(k-1, src)) begin
            exp = 2'b10;
            tag = writes(k-2, src) ? "R7 priority" : "R4 one-ahead";
        end else if (src != 5'd0 && writes(k-2, src)) begin
            exp = 2'b01;
            tag = "R5 two-ahead";
        end else begin
            exp = 2'b00;
            if (src == 5'd0) tag = "R8 zero src";
            else if (k >= 1 && !h_wen[k-1] && h_rd[k-1] == src) tag = "R9 non-writer";
            else tag = "R10 no match";
        end
        chk(tag, {30'd0, act}, {30'd0, exp});
    endtask

    // outputs after the edge that captured issue cnt-1
    task automatic check_outputs();
        int j;
        if (cnt == 0) return;
        chk_sel(cnt-1, h_rs[cnt-1], fwd_sel_a);
        chk_sel(cnt-1, h_rt[cnt-1], fwd_sel_b);
        j = cnt - 3;
        if (j < 0) begin
            chk("R1 no early commit", {31'd0, wb_valid}, 32'd0);
        end else begin
            logic ev;
            ev = h_wen[j] && h_rd[j] != 5'd0;
            if (h_wen[j] && h_rd[j] == 5'd0)
                chk("R8 zero dest", {31'd0, wb_valid}, {31'd0, ev});
            else if (!h_wen[j])
                chk("R9 no commit", {31'd0, wb_valid}, {31'd0, ev});
            else
                chk("R2 latency", {31'd0, wb_valid}, {31'd0, ev});
            if (ev) begin
                chk("R2 wb reg", {27'd0, wb_reg}, {27'd0, h_rd[j]});
                chk(h_d3[j] ? "R6 decode bypass" : "R3 result", wb_data, h_res[j]);
            end
        end
    endtask

    task automatic issue(input logic wen, input logic [3:0] op, input logic [4:0] rs,
                         input logic [4:0] rt, input logic [4:0] rd,
                         input logic isel, input logic [31:0] imm);
        logic [31:0] a, t, b, r;
        logic [4:0]  sa;
        @(negedge clk);
        check_outputs();
        a  = mreg[rs];
        t  = mreg[rt];
        b  = isel ? imm : t;
        sa = isel ? imm[4:0] : a[4:0];
        r  = ref_alu(op, a, b, t, sa);
        h_wen[cnt] = wen;
        h_rd[cnt]  = rd;
        h_rs[cnt]  = rs;
        h_rt[cnt]  = rt;
        h_res[cnt] = r;
        h_d3[cnt]  = (writes(cnt-3, rs) && !writes(cnt-2, rs) && !writes(cnt-1, rs)) ||
                     (writes(cnt-3, rt) && !writes(cnt-2, rt) && !writes(cnt-1, rt));
        if (wen && rd != 5'd0) mreg[rd] = r;
        id_wen = wen; id_op = op; id_rs = rs; id_rt = rt; id_rd = rd;
        id_imm_sel = isel; id_imm = imm;
        cnt++;
    endtask

    task automatic nop();
        issue(1'b0, 4'd0, 5'd0, 5'd0, 5'd0, 1'b0, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
        rst_n = 1'b0;
        id_wen = 1'b0; id_op = 4'd0; id_rs = 5'd0; id_rt = 5'd0; id_rd = 5'd0;
        id_imm_sel = 1'b0; id_imm = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        chk("R1 wb_valid", {31'd0, wb_valid}, 32'd0);
        chk("R1 sel_a", {30'd0, fwd_sel_a}, 32'd0);
        chk("R1 sel_b", {30'd0, fwd_sel_b}, 32'd0);

        // R1: registers read zero right after reset
        issue(1'b1, 4'd3, 5'd4, 5'd5, 5'd6, 1'b0, 32'd0);
        // R4: distance-1 chain, and R10 mixed sources
        issue(1'b1, 4'd0, 5'd0, 5'd0, 5'd1, 1'b1, 32'd5);
        issue(1'b1, 4'd0, 5'd1, 5'd0, 5'd1, 1'b1, 32'd1);
        issue(1'b1, 4'd1, 5'd1, 5'd1, 5'd2, 1'b0, 32'd0);
        // R5: distance 2, R6: distance 3
        issue(1'b1, 4'd0, 5'd0, 5'd0, 5'd3, 1'b1, 32'hFFFF_FFF0);
        nop();
        issue(1'b1, 4'd4, 5'd3, 5'd1, 5'd4, 1'b0, 32'd0);
        issue(1'b1, 4'd10, 5'd0, 5'd3, 5'd5, 1'b1, 32'd2);
        nop(); nop();
        issue(1'b1, 4'd6, 5'd5, 5'd1, 5'd6, 1'b0, 32'd0);
        // R7: two writes to the same register, then a read of both operands
        issue(1'b1, 4'd0, 5'd0, 5'd0, 5'd2, 1'b1, 32'd7);
        issue(1'b1, 4'd0, 5'd0, 5'd0, 5'd2, 1'b1, 32'd9);
        issue(1'b1, 4'd0, 5'd2, 5'd2, 5'd7, 1'b0, 32'd0);
        // R8: write to register 0, then read it back
        issue(1'b1, 4'd0, 5'd1, 5'd0, 5'd0, 1'b1, 32'd55);
        issue(1'b1, 4'd3, 5'd0, 5'd0, 5'd7, 1'b0, 32'd0);
        // R9: non-writer naming register 3, then read register 3
        issue(1'b0, 4'd0, 5'd0, 5'd0, 5'd3, 1'b1, 32'd99);
        issue(1'b1, 4'd0, 5'd3, 5'd3, 5'd4, 1'b0, 32'd0);
        // R3: variable shift, load-upper, unsigned compare, unused code
        issue(1'b1, 4'd8, 5'd1, 5'd3, 5'd5, 1'b0, 32'd0);
        issue(1'b1, 4'd11, 5'd0, 5'd0, 5'd6, 1'b1, 32'h0000_ABCD);
        issue(1'b1, 4'd7, 5'd6, 5'd3, 5'd7, 1'b0, 32'd0);
        issue(1'b1, 4'd13, 5'd6, 5'd3, 5'd1, 1'b0, 32'd0);

        // constrained random over a small register set to crowd hazards
        for (int n = 0; n < NRAND; n++) begin
            logic        w;
            logic [31:0] im;
            w  = ($urandom_range(0, 9) < 8);
            im = ($urandom_range(0, 3) == 0) ? $urandom() : 32'($urandom_range(0, 40));
            issue(w, 4'($urandom_range(0, 15)), 5'($urandom_range(0, 7)),
                  5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)),
                  1'($urandom_range(0, 1)), im);
        end

        // flush the pipe so the last instructions are checked
        repeat (4) nop();
        @(negedge clk);
        check_outputs();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule